// File: doc/BRIEF.md
# Register-Triggered Mu-Law Compander

This block is a small G.711 mu-law codec that sits behind a byte-wide register port. It has two data registers, a high byte and a low byte, and one configuration register. A write to a data register does the conversion in the same clock edge, so no separate start command is needed. When the compress mode is selected, writing the low byte compresses the 16-bit value {high, newly written low} into an 8-bit code, which is placed in the high register. When the expand mode is selected, writing an 8-bit code into the high register replaces the high:low pair with the 16-bit linear value.

The conversions run only while the serial audio port flag in the configuration register is clear. If that flag is set, or if both mode enables are set at once, the data registers act as plain storage. The block does not hold a write back: every write is taken on the edge where `wr_en` is high, so the port has no back-pressure. Reads are combinational from the stored registers.

Top module: `ulaw_regcodec`

## Requirements
- R1: After reset, the high register (address 0), the low register (address 1) and the configuration register (address 2) all read 0x00.
- R2: The configuration register at address 2 holds bit 0 = port enable, bit 1 = expand enable and bit 2 = compress enable. Bits 7..3 read as 0. Address 3 reads 0x00, and a write to address 3 changes no register.
- R3: With config 0x04 (compress only), a write of byte L to address 1 loads the mu-law code of the 16-bit two's-complement value {H, L} into the high register, where H is the previous high byte. L is stored in the low register. The code is formed as follows: sign bit; magnitude clipped at 32635; bias of 132 added; exponent set to the position of the top set bit minus 7; a 4-bit mantissa taken from the bits just below that top bit; all 8 bits then inverted.
- R4: With config 0x04, a write to address 0 stores the byte unchanged.
- R5: With config 0x02 (expand only), a write of code C to address 0 sets {high, low} to the linear value of C. The code is inverted, then ((mantissa<<3)+132)<<exponent is computed, 132 is subtracted, and the sign is applied.
- R6: With config 0x02, a write to address 1 stores the byte unchanged.
- R7: Magnitudes above 32635, including -32768, saturate to code 0x80 (positive) or 0x00 (negative).
- R8: With both enables set and the port flag clear (config 0x06), no conversion happens, and writes to either data address store the byte unchanged.
- R9: With the port flag set (e.g. config 0x05 or 0x03), no conversion happens, and data writes store the byte unchanged.
- R10: A conversion result is readable in the cycle after the triggering write. A read during the triggering write cycle returns the previous contents.
- R11: A configuration change applies to data writes after the configuration write, and does not alter the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken on every asserted edge |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Combinational read data |

## Verification
A read of the high register and the write that triggers a compression can happen in the same cycle. The bench provokes this by holding `rd_addr` on the high register while it drives the low-byte write. It samples between the edges, expecting the old high byte before the edge and the new code after it. A configuration write followed directly by a data write is the second pairing. The bench judges it by whether the very next data write already uses the new mode and whether the data bytes were left untouched.

// File: rtl/ulaw_pkg.sv
package ulaw_pkg;

  localparam int REG_ADDR_W = 2;
  localparam int CFG_W      = 3;

  localparam logic [REG_ADDR_W-1:0] A_HIGH = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_LOW  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_CFG  = 2'd2;

  typedef struct packed {
    logic comp_en;   // bit 2
    logic exp_en;    // bit 1
    logic port_en;   // bit 0
  } cfg_t;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_COMP  = 2'd1,
    MODE_EXP   = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(cfg_t c);
    if (c.port_en)                 return MODE_PLAIN;
    else if (c.comp_en && !c.exp_en) return MODE_COMP;
    else if (c.exp_en && !c.comp_en) return MODE_EXP;
    else                           return MODE_PLAIN;
  endfunction

endpackage

// File: rtl/ulaw_compress.sv
module ulaw_compress #(
  parameter int LIN_W  = 16,
  parameter int EXP_W  = 3,
  parameter int MAN_W  = 4,
  parameter int CLIP   = 32635,
  parameter int BIAS   = 132
) (
  input  logic [LIN_W-1:0]       lin,
  output logic [EXP_W+MAN_W:0]   code
);
  localparam int MAG_W   = LIN_W + 1;
  localparam int SEGS    = 1 << EXP_W;
  localparam int SEG_LSB = MAN_W + EXP_W;

  logic             sign;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] clipped;
  logic [MAG_W-1:0] biased;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;

  always_comb begin
    sign    = lin[LIN_W-1];
    mag     = sign ? ({1'b0, ~lin} + MAG_W'(1)) : {1'b0, lin};
    clipped = (mag > MAG_W'(CLIP)) ? MAG_W'(CLIP) : mag;
    biased  = clipped + MAG_W'(BIAS);
    expo    = '0;
    for (int e = 0; e < SEGS; e++) begin
      if (biased[e + SEG_LSB]) expo = EXP_W'(e);
    end
    mant = MAN_W'(biased >> (32'(expo) + MAN_W - 1));
    code = ~{sign, expo, mant};
  end

endmodule

// File: rtl/ulaw_expand.sv
module ulaw_expand #(
  parameter int LIN_W = 16,
  parameter int EXP_W = 3,
  parameter int MAN_W = 4,
  parameter int BIAS  = 132
) (
  input  logic [EXP_W+MAN_W:0] code,
  output logic [LIN_W-1:0]     lin
);
  localparam int CODE_W = EXP_W + MAN_W + 1;

  logic [CODE_W-1:0] inv;
  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [MAN_W-1:0]  mant;
  logic [LIN_W-1:0]  seg;
  logic [LIN_W-1:0]  mag;

  always_comb begin
    inv  = ~code;
    sign = inv[CODE_W-1];
    expo = inv[CODE_W-2 -: EXP_W];
    mant = inv[MAN_W-1:0];
    seg  = (LIN_W'({mant, 3'b000}) + LIN_W'(BIAS)) << expo;
    mag  = seg - LIN_W'(BIAS);
    lin  = sign ? (LIN_W'(0) - mag) : mag;
  end

  // R5: the largest expanded magnitude is below full scale
  always_comb begin
    if (!$isunknown(code)) begin
      p_no_fullscale_r5: assert (lin != {1'b1, {(LIN_W-1){1'b0}}})
        else $error("expanded value reached negative full scale");
    end
  end

endmodule

// File: rtl/ulaw_regbank.sv
module ulaw_regbank
  import ulaw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic [DATA_W-1:0]     high_q,
  input  logic [DATA_W-1:0]     comp_code,
  input  logic [2*DATA_W-1:0]   exp_lin
);
  logic [DATA_W-1:0] low_q;
  cfg_t              cfg_q;
  mode_e             mode;

  assign mode = decode_mode(cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_HIGH: begin
          if (mode == MODE_EXP) {high_q, low_q} <= exp_lin;
          else                  high_q <= wr_data;
        end
        A_LOW: begin
          if (mode == MODE_COMP) high_q <= comp_code;
          low_q <= wr_data;
        end
        A_CFG:   cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_HIGH:  rd_data = high_q;
      A_LOW:   rd_data = low_q;
      A_CFG:   rd_data = DATA_W'(cfg_q);
      default: rd_data = '0;
    endcase
  end

  // R3: the code's top bit is the inverse of the sign of the input pair
  p_comp_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LOW && mode == MODE_COMP)
      |=> (high_q[DATA_W-1] == ~$past(high_q[DATA_W-1])) && (low_q == $past(wr_data)))
    else $error("compress sign or low byte wrong");

  // R5: every expanded value is a multiple of four
  p_exp_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HIGH && mode == MODE_EXP) |=> (low_q[1:0] == 2'b00))
    else $error("expanded value not aligned");

  // R8, R9: plain mode stores the high byte unchanged
  p_plain_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HIGH && mode == MODE_PLAIN) |=> (high_q == $past(wr_data)))
    else $error("plain high write altered");

  // R10: without a write nothing moves
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(high_q) && $stable(low_q) && $stable(cfg_q)))
    else $error("register changed without write");

  // R2: the unused address has no effect
  p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(high_q) && $stable(low_q) && $stable(cfg_q)))
    else $error("spare address write changed state");

  // R11: a config write leaves the data bytes alone
  p_cfg_keeps_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CFG) |=> ($stable(high_q) && $stable(low_q)))
    else $error("config write touched data");

endmodule

// File: rtl/ulaw_regcodec.sv
module ulaw_regcodec #(
  parameter int DATA_W = 8,
  parameter int CLIP   = 32635,
  parameter int BIAS   = 132
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LIN_W = 2 * DATA_W;
  localparam int EXP_W = 3;
  localparam int MAN_W = DATA_W - EXP_W - 1;

  logic [DATA_W-1:0] high_q;
  logic [DATA_W-1:0] comp_code;
  logic [LIN_W-1:0]  exp_lin;

  ulaw_compress #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .CLIP(CLIP), .BIAS(BIAS)
  ) u_comp (
    .lin  ({high_q, wr_data}),
    .code (comp_code)
  );

  ulaw_expand #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)
  ) u_exp (
    .code (wr_data),
    .lin  (exp_lin)
  );

  ulaw_regbank #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .high_q    (high_q),
    .comp_code (comp_code),
    .exp_lin   (exp_lin)
  );

endmodule

// File: tb/ulaw_regcodec_test.sv
`timescale 1ns/1ps
module ulaw_regcodec_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ulaw_regcodec uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {mode (0 compress, 1 expand), input, expected}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h00FF},
    {1'b0, 16'hFFFF, 16'h007F},
    {1'b0, 16'h03E8, 16'h00CE},
    {1'b0, 16'hFC18, 16'h004E},
    {1'b0, 16'h0064, 16'h00F2},
    {1'b0, 16'h7FFF, 16'h0080},
    {1'b0, 16'h8000, 16'h0000},
    {1'b0, 16'h7F7B, 16'h0080},
    {1'b0, 16'h8001, 16'h0000},
    {1'b1, 16'h00FF, 16'h0000},
    {1'b1, 16'h007F, 16'h0000},
    {1'b1, 16'h0080, 16'h7D7C},
    {1'b1, 16'h0000, 16'h8284},
    {1'b1, 16'h00CE, 16'h03DC},
    {1'b1, 16'h004E, 16'hFC24},
    {1'b1, 16'h00F2, 16'h0068}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] h, l;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(2'd0, h); check("R1 high", {8'h0, h}, 16'h0000);
    rd(2'd1, h); check("R1 low",  {8'h0, h}, 16'h0000);
    rd(2'd2, h); check("R1 cfg",  {8'h0, h}, 16'h0000);

    // vector table walk: R3, R5, R7
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32] == 1'b0) begin
        wr(2'd2, 8'h04);
        wr(2'd0, VEC[i][31:24]);
        wr(2'd1, VEC[i][23:16]);
        rd(2'd0, h); rd(2'd1, l);
        check("R3/R7 code", {8'h0, h}, VEC[i][15:0]);
        check("R3 low kept", {8'h0, l}, {8'h0, VEC[i][23:16]});
      end else begin
        wr(2'd2, 8'h02);
        wr(2'd0, VEC[i][23:16]);
        rd(2'd0, h); rd(2'd1, l);
        check("R5 linear", {h, l}, VEC[i][15:0]);
      end
    end

    // R2 config field masking and spare address
    wr(2'd2, 8'hF9);
    rd(2'd2, h); check("R2 cfg mask", {8'h0, h}, 16'h0001);
    wr(2'd0, 8'h5A); wr(2'd1, 8'hA5);
    wr(2'd3, 8'hFF);
    rd(2'd3, h); check("R2 spare reads 0", {8'h0, h}, 16'h0000);
    rd(2'd0, h); rd(2'd1, l); check("R2 spare write ignored", {h, l}, 16'h5AA5);
    rd(2'd2, h); check("R2 cfg unchanged", {8'h0, h}, 16'h0001);

    // R4 compress mode high write is plain
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h12);
    rd(2'd0, h); check("R4 high plain", {8'h0, h}, 16'h0012);

    // R6 expand mode low write is plain
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h33);
    rd(2'd0, h); rd(2'd1, l); check("R6 low plain", {h, l}, 16'h1233);

    // R8 both enables set
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h55);
    rd(2'd0, h); rd(2'd1, l); check("R8 no conversion", {h, l}, 16'h8055);

    // R9 port enabled with compress and with expand
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h03); wr(2'd1, 8'hE8);
    rd(2'd0, h); rd(2'd1, l); check("R9 no compress", {h, l}, 16'h03E8);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h80);
    rd(2'd0, h); rd(2'd1, l); check("R9 no expand", {h, l}, 16'h80E8);

    // R11 config change keeps data, next write uses new mode
    wr(2'd2, 8'h04);
    rd(2'd0, h); rd(2'd1, l); check("R11 data kept", {h, l}, 16'h80E8);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hE8);
    rd(2'd0, h); check("R11 new mode applied", {8'h0, h}, 16'h00CE);

    // R10 read during the triggering write, then after it
    wr(2'd0, 8'h03);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'hE8; rd_addr = 2'd0;
    #0.5;
    check("R10 old value during write", {8'h0, rd_data}, 16'h0003);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R10 result next cycle", {8'h0, rd_data}, 16'h00CE);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule